// File: doc/BRIEF.md
# Transceiver PHY Control and Status Register Block

This block is the software-visible control point for a multi-channel serial transceiver PHY. A master reaches it through a 32-bit slave port with a 9-bit word address, separate read and write strobes and a wait-request handshake. The block holds per-channel bitmasks that drive calibration powerdown, serial loopback and the two clock-recovery lock modes. It also returns per-channel and per-PLL lock status gathered from the analog side.

Per-lane PCS controls are reached indirectly. A lane-select word picks one lane, and a small window of per-lane words then reads or writes that lane's copy. The controls include TX slip count, TX and RX polarity inversion, bit and byte reversal, and pattern-alignment enable. There is also an RX bit-slip request that fires a one-cycle pulse on each rising write. If any lock-mode bit is set, the block flags manual mode to the reset logic.

Top module: `phy_ctrl_regs`

## Requirements
- R1: After reset, every control output, manual_mode and rdata are zero, and wait_req is low while no read is presented.
- R2: A read raises wait_req in its first cycle and drops it in the next cycle, with rdata holding the addressed word. A write completes in the cycle it is presented and never raises wait_req.
- R3: Words 0x021 (calibration powerdown), 0x061 (serial loopback), 0x064 (lock-to-data) and 0x065 (lock-to-reference) are read/write channel masks. Bit n drives channel n of the matching output, and bits at or above NUM_CH read as zero.
- R4: Word 0x022 returns the TX PLL lock inputs in bits [NUM_PLL-1:0]. Words 0x066 and 0x067 return the per-channel lock-to-data and lock-to-reference status inputs.
- R5: manual_mode is high in the cycle after any write leaves a nonzero lock-to-data or lock-to-reference mask, and it is low once both masks are zero.
- R6: Word 0x080 stores an 8-bit lane select that reads back zero-extended. Per-lane words 0x081 to 0x085 act only on the selected lane, and other lanes are left unchanged.
- R7: In per-lane word 0x083, bits [5:1] set the lane's TX slip count and bit 0 sets TX polarity inversion. In word 0x084, bit 0 sets RX polarity inversion.
- R8: In per-lane word 0x085, bit 2 enables byte reversal, bit 1 enables bit reversal and bit 0 enables pattern alignment. Bit 3 reads back as stored.
- R9: A write to word 0x085 that takes bit 3 of the selected lane from 0 to 1 raises that lane's rx_slip_pulse for exactly one cycle, the cycle after the write. Writing 1 while bit 3 is already 1 gives no pulse.
- R10: Per-lane word 0x081 returns the lane's received slip count in bits [5:1], with all other bits zero. Word 0x082 reads as zero.
- R11: Addresses outside the map read as zero and writes to them change nothing. With a lane select of NUM_LANE or above, per-lane words read zero and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 9 | Word address |
| wdata | input | 32 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| wait_req | output | 1 | Stall request, high for the first cycle of a read |
| tx_pll_locked | input | NUM_PLL | TX PLL lock flags |
| cdr_ltd_stat | input | NUM_CH | Per-channel locked-to-data status |
| cdr_ltr_stat | input | NUM_CH | Per-channel locked-to-reference status |
| rx_slip_cnt | input | NUM_LANE*5 | Per-lane slip count from the word aligner |
| cal_pd | output | NUM_CH | Calibration powerdown per channel |
| serial_lpbk | output | NUM_CH | Serial loopback per channel |
| cdr_ltd_req | output | NUM_CH | Lock-to-data request per channel |
| cdr_ltr_req | output | NUM_CH | Lock-to-reference request per channel |
| manual_mode | output | 1 | Reset logic in manual mode |
| tx_slip_sel | output | NUM_LANE*5 | TX slip count per lane |
| tx_inv | output | NUM_LANE | TX polarity inversion per lane |
| rx_inv | output | NUM_LANE | RX polarity inversion per lane |
| rx_slip_pulse | output | NUM_LANE | One-cycle RX bit-slip pulse per lane |
| byte_rev | output | NUM_LANE | Byte reversal enable per lane |
| bit_rev | output | NUM_LANE | Bit reversal enable per lane |
| pat_align | output | NUM_LANE | Pattern alignment enable per lane |

## Verification
The assertions assume that the master never raises rd and wr in the same cycle. They also assume that it holds rd and addr steady until wait_req has dropped, so that a read spans exactly two cycles. The bench drives each transfer from a task that raises one strobe at a time on the falling edge and keeps it there through the completing edge. It lowers the strobe only after that edge, which keeps every transfer within these rules.

// File: rtl/phy_regs_pkg.sv
// Package: word addresses and field widths shared by the PHY register block.
// Assumes a 32-bit data path and a 9-bit word address.
package phy_regs_pkg;
    localparam int ADDR_W     = 9;
    localparam int DATA_W     = 32;
    localparam int SLIP_W     = 5;
    localparam int LANE_SEL_W = 8;

    localparam logic [ADDR_W-1:0] A_CAL_PD   = 9'h021;
    localparam logic [ADDR_W-1:0] A_PLL_LOCK = 9'h022;
    localparam logic [ADDR_W-1:0] A_LPBK     = 9'h061;
    localparam logic [ADDR_W-1:0] A_LTD      = 9'h064;
    localparam logic [ADDR_W-1:0] A_LTR      = 9'h065;
    localparam logic [ADDR_W-1:0] A_LTD_ST   = 9'h066;
    localparam logic [ADDR_W-1:0] A_LTR_ST   = 9'h067;
    localparam logic [ADDR_W-1:0] A_LANE_SEL = 9'h080;
    localparam logic [ADDR_W-1:0] A_L_RXST   = 9'h081;
    localparam logic [ADDR_W-1:0] A_L_TXST   = 9'h082;
    localparam logic [ADDR_W-1:0] A_L_TXCTL  = 9'h083;
    localparam logic [ADDR_W-1:0] A_L_RXPOL  = 9'h084;
    localparam logic [ADDR_W-1:0] A_L_RXWA   = 9'h085;

    // Bit positions inside the per-lane alignment word
    localparam int WA_SLIP  = 3;
    localparam int WA_BYTE  = 2;
    localparam int WA_BIT   = 1;
    localparam int WA_ALIGN = 0;
endpackage

// File: rtl/phy_bus_port.sv
// Module: slave-port handshake. Stalls every read for one cycle while it
// registers the read word, and passes writes through with no stall.
// Assumes the master never presents rd and wr together and holds rd/addr
// while wait_req is high.
module phy_bus_port
    import phy_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] rd_word,
    output logic              wait_req,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_en
);
    logic              rd_done_q;
    logic [DATA_W-1:0] rdata_q;

    assign wait_req = rd & ~rd_done_q;
    assign wr_en    = wr & ~rd;
    assign rdata    = rdata_q;

    // Capture the read word in the first read cycle, release the stall next
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_done_q <= 1'b0;
            rdata_q   <= '0;
        end else if (rd && !rd_done_q) begin
            rd_done_q <= 1'b1;
            rdata_q   <= rd_word;
        end else begin
            rd_done_q <= 1'b0;
        end
    end
endmodule

// File: rtl/phy_pma_regs.sv
// Module: per-channel mask registers for calibration powerdown, loopback and
// the two clock-recovery lock modes, plus the manual-mode flag.
// Assumes wr_en is a single-cycle qualified write strobe.
module phy_pma_regs
    import phy_regs_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] wmask,
    output logic [NUM_CH-1:0] cal_pd,
    output logic [NUM_CH-1:0] serial_lpbk,
    output logic [NUM_CH-1:0] cdr_ltd_req,
    output logic [NUM_CH-1:0] cdr_ltr_req,
    output logic              manual_mode
);
    logic [NUM_CH-1:0] cal_q, lpbk_q, ltd_q, ltr_q;

    // Store each mask on a write to its own word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q  <= '0;
            lpbk_q <= '0;
            ltd_q  <= '0;
            ltr_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CAL_PD: cal_q  <= wmask;
                A_LPBK:   lpbk_q <= wmask;
                A_LTD:    ltd_q  <= wmask;
                A_LTR:    ltr_q  <= wmask;
                default:  ;
            endcase
        end
    end

    assign cal_pd      = cal_q;
    assign serial_lpbk = lpbk_q;
    assign cdr_ltd_req = ltd_q;
    assign cdr_ltr_req = ltr_q;
    assign manual_mode = |{ltd_q, ltr_q};
endmodule

// File: rtl/phy_lane_regs.sv
// Module: per-lane PCS control copies reached through the lane select.
// Generates the one-cycle RX bit-slip pulse on a rising write of the request bit.
// Assumes lane_sel is stable across the write that uses it.
module phy_lane_regs
    import phy_regs_pkg::*;
#(
    parameter int NUM_LANE = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [SLIP_W:0]            wbits,
    input  logic [LANE_SEL_W-1:0]      lane_sel,
    input  logic [NUM_LANE*SLIP_W-1:0] rx_slip_cnt,
    output logic [NUM_LANE*SLIP_W-1:0] tx_slip_sel,
    output logic [NUM_LANE-1:0]        tx_inv,
    output logic [NUM_LANE-1:0]        rx_inv,
    output logic [NUM_LANE-1:0]        rx_slip_pulse,
    output logic [NUM_LANE-1:0]        byte_rev,
    output logic [NUM_LANE-1:0]        bit_rev,
    output logic [NUM_LANE-1:0]        pat_align,
    output logic [DATA_W-1:0]          lane_rdata
);
    logic [SLIP_W-1:0]   tx_slip_q [NUM_LANE];
    logic [NUM_LANE-1:0] tx_inv_q, rx_inv_q, slip_req_q, slip_pulse_q;
    logic [NUM_LANE-1:0] byte_q, bit_q, align_q;

    // Update the selected lane's fields and form the bit-slip pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LANE; i++) tx_slip_q[i] <= '0;
            tx_inv_q     <= '0;
            rx_inv_q     <= '0;
            slip_req_q   <= '0;
            slip_pulse_q <= '0;
            byte_q       <= '0;
            bit_q        <= '0;
            align_q      <= '0;
        end else begin
            for (int i = 0; i < NUM_LANE; i++) begin
                slip_pulse_q[i] <= 1'b0;
                if (wr_en && lane_sel == LANE_SEL_W'(i)) begin
                    case (addr)
                        A_L_TXCTL: begin
                            tx_slip_q[i] <= wbits[SLIP_W:1];
                            tx_inv_q[i]  <= wbits[0];
                        end
                        A_L_RXPOL: rx_inv_q[i] <= wbits[0];
                        A_L_RXWA: begin
                            slip_pulse_q[i] <= wbits[WA_SLIP] & ~slip_req_q[i];
                            slip_req_q[i]   <= wbits[WA_SLIP];
                            byte_q[i]       <= wbits[WA_BYTE];
                            bit_q[i]        <= wbits[WA_BIT];
                            align_q[i]      <= wbits[WA_ALIGN];
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Flatten per-lane slip counts onto the output bus
    for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane_out
        assign tx_slip_sel[g*SLIP_W +: SLIP_W] = tx_slip_q[g];
    end

    assign tx_inv        = tx_inv_q;
    assign rx_inv        = rx_inv_q;
    assign rx_slip_pulse = slip_pulse_q;
    assign byte_rev      = byte_q;
    assign bit_rev       = bit_q;
    assign pat_align     = align_q;

    // Select the addressed per-lane word for the selected lane
    always_comb begin
        lane_rdata = '0;
        for (int i = 0; i < NUM_LANE; i++) begin
            if (lane_sel == LANE_SEL_W'(i)) begin
                case (addr)
                    A_L_RXST:  lane_rdata = DATA_W'({rx_slip_cnt[i*SLIP_W +: SLIP_W], 1'b0});
                    A_L_TXCTL: lane_rdata = DATA_W'({tx_slip_q[i], tx_inv_q[i]});
                    A_L_RXPOL: lane_rdata = DATA_W'(rx_inv_q[i]);
                    A_L_RXWA:  lane_rdata = DATA_W'({slip_req_q[i], byte_q[i], bit_q[i], align_q[i]});
                    default:   lane_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/phy_ctrl_regs.sv
// Module: top of the PHY control/status register block. Decodes the word
// address, holds the lane select and merges read data from the sub-blocks.
// Assumes NUM_CH <= 32 and NUM_PLL <= 32.
module phy_ctrl_regs
    import phy_regs_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int NUM_LANE = 4,
    parameter int NUM_PLL  = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [8:0]                 addr,
    input  logic [31:0]                wdata,
    input  logic                       wr,
    input  logic                       rd,
    output logic [31:0]                rdata,
    output logic                       wait_req,
    input  logic [NUM_PLL-1:0]         tx_pll_locked,
    input  logic [NUM_CH-1:0]          cdr_ltd_stat,
    input  logic [NUM_CH-1:0]          cdr_ltr_stat,
    input  logic [NUM_LANE*5-1:0]      rx_slip_cnt,
    output logic [NUM_CH-1:0]          cal_pd,
    output logic [NUM_CH-1:0]          serial_lpbk,
    output logic [NUM_CH-1:0]          cdr_ltd_req,
    output logic [NUM_CH-1:0]          cdr_ltr_req,
    output logic                       manual_mode,
    output logic [NUM_LANE*5-1:0]      tx_slip_sel,
    output logic [NUM_LANE-1:0]        tx_inv,
    output logic [NUM_LANE-1:0]        rx_inv,
    output logic [NUM_LANE-1:0]        rx_slip_pulse,
    output logic [NUM_LANE-1:0]        byte_rev,
    output logic [NUM_LANE-1:0]        bit_rev,
    output logic [NUM_LANE-1:0]        pat_align
);
    logic                  wr_en;
    logic [DATA_W-1:0]     rd_word;
    logic [DATA_W-1:0]     lane_rdata;
    logic [LANE_SEL_W-1:0] lane_sel_q;
    wire                   unused_wdata = ^wdata;

    phy_bus_port u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (rd),
        .wr       (wr),
        .rd_word  (rd_word),
        .wait_req (wait_req),
        .rdata    (rdata),
        .wr_en    (wr_en)
    );

    phy_pma_regs #(.NUM_CH(NUM_CH)) u_pma (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wmask       (wdata[NUM_CH-1:0]),
        .cal_pd      (cal_pd),
        .serial_lpbk (serial_lpbk),
        .cdr_ltd_req (cdr_ltd_req),
        .cdr_ltr_req (cdr_ltr_req),
        .manual_mode (manual_mode)
    );

    phy_lane_regs #(.NUM_LANE(NUM_LANE)) u_lane (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .addr          (addr),
        .wbits         (wdata[SLIP_W:0]),
        .lane_sel      (lane_sel_q),
        .rx_slip_cnt   (rx_slip_cnt),
        .tx_slip_sel   (tx_slip_sel),
        .tx_inv        (tx_inv),
        .rx_inv        (rx_inv),
        .rx_slip_pulse (rx_slip_pulse),
        .byte_rev      (byte_rev),
        .bit_rev       (bit_rev),
        .pat_align     (pat_align),
        .lane_rdata    (lane_rdata)
    );

    // Hold the lane select written at its own word
    always_ff @(posedge clk) begin
        if (!rst_n)                          lane_sel_q <= '0;
        else if (wr_en && addr == A_LANE_SEL) lane_sel_q <= wdata[LANE_SEL_W-1:0];
    end

    // Merge the addressed word for the read register
    always_comb begin
        case (addr)
            A_CAL_PD:   rd_word = DATA_W'(cal_pd);
            A_PLL_LOCK: rd_word = DATA_W'(tx_pll_locked);
            A_LPBK:     rd_word = DATA_W'(serial_lpbk);
            A_LTD:      rd_word = DATA_W'(cdr_ltd_req);
            A_LTR:      rd_word = DATA_W'(cdr_ltr_req);
            A_LTD_ST:   rd_word = DATA_W'(cdr_ltd_stat);
            A_LTR_ST:   rd_word = DATA_W'(cdr_ltr_stat);
            A_LANE_SEL: rd_word = DATA_W'(lane_sel_q);
            A_L_RXST, A_L_TXST, A_L_TXCTL, A_L_RXPOL, A_L_RXWA:
                        rd_word = lane_rdata;
            default:    rd_word = '0;
        endcase
    end
endmodule

// File: rtl/phy_ctrl_regs_chk.sv
// Module: protocol and behaviour checker bound to phy_ctrl_regs.
// Assumes a master that never overlaps rd and wr.
module phy_ctrl_regs_chk #(
    parameter int NUM_CH   = 4,
    parameter int NUM_LANE = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [8:0]          addr,
    input logic [31:0]         wdata,
    input logic                wr,
    input logic                rd,
    input logic [31:0]         rdata,
    input logic                wait_req,
    input logic                manual_mode,
    input logic [NUM_LANE-1:0] rx_slip_pulse
);
    // R2: a stalled read is released one cycle later
    assert_read_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && wait_req) |=> !wait_req);

    // R2: a write is never stalled
    assert_write_nowait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd) |-> !wait_req);

    // R2: master keeps the strobes exclusive
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr));

    // R5: a nonzero lock-to-data mask puts the reset logic in manual mode
    assert_manual_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd && addr == 9'h064 && wdata[NUM_CH-1:0] != '0) |=> manual_mode);

    // R9: at most one lane pulses, and never two cycles running
    assert_slip_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_slip_pulse));

    assert_slip_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_slip_pulse != '0) |=> ((rx_slip_pulse & $past(rx_slip_pulse)) == '0));

    // R11: an unmapped read returns zero
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && wait_req && addr == 9'h1FF) |=> (rdata == 32'h0));
endmodule

bind phy_ctrl_regs phy_ctrl_regs_chk #(.NUM_CH(NUM_CH), .NUM_LANE(NUM_LANE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr          (addr),
    .wdata         (wdata),
    .wr            (wr),
    .rd            (rd),
    .rdata         (rdata),
    .wait_req      (wait_req),
    .manual_mode   (manual_mode),
    .rx_slip_pulse (rx_slip_pulse)
);

// File: tb/phy_ctrl_regs_tb.sv
// Bench: vector table of writes and read-compares, then directed checks.
module phy_ctrl_regs_tb;
    localparam int NUM_CH = 4, NUM_LANE = 4, NUM_PLL = 2;
    localparam int NVEC = 27;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] rdata;
    logic        wait_req;
    logic [NUM_PLL-1:0]    tx_pll_locked = 2'b10;
    logic [NUM_CH-1:0]     cdr_ltd_stat = 4'b0101;
    logic [NUM_CH-1:0]     cdr_ltr_stat = 4'b1010;
    logic [NUM_LANE*5-1:0] rx_slip_cnt = {5'd6, 5'd5, 5'd4, 5'd3};
    logic [NUM_CH-1:0]     cal_pd, serial_lpbk, cdr_ltd_req, cdr_ltr_req;
    logic                  manual_mode;
    logic [NUM_LANE*5-1:0] tx_slip_sel;
    logic [NUM_LANE-1:0]   tx_inv, rx_inv, rx_slip_pulse, byte_rev, bit_rev, pat_align;

    int  n_chk = 0, n_err = 0;
    bit  hs_ok = 1'b1;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    phy_ctrl_regs #(.NUM_CH(NUM_CH), .NUM_LANE(NUM_LANE), .NUM_PLL(NUM_PLL)) u_dut (.*);

    // {is_read, addr, wdata, expected}
    localparam logic [73:0] VEC [NVEC] = '{
        {1'b0, 9'h021, 32'hFFFF_FFFF, 32'h0},        // R3
        {1'b1, 9'h021, 32'h0, 32'h0000_000F},        // R3 upper bits zero
        {1'b0, 9'h061, 32'h5, 32'h0},
        {1'b1, 9'h061, 32'h0, 32'h5},                // R3
        {1'b0, 9'h065, 32'h3, 32'h0},
        {1'b1, 9'h065, 32'h0, 32'h3},                // R3
        {1'b1, 9'h022, 32'h0, 32'h2},                // R4
        {1'b1, 9'h066, 32'h0, 32'h5},                // R4
        {1'b1, 9'h067, 32'h0, 32'hA},                // R4
        {1'b0, 9'h080, 32'h102, 32'h0},
        {1'b1, 9'h080, 32'h0, 32'h2},                // R6
        {1'b0, 9'h083, 32'h2B, 32'h0},
        {1'b1, 9'h083, 32'h0, 32'h2B},               // R7
        {1'b0, 9'h084, 32'hFFFF_FFFF, 32'h0},
        {1'b1, 9'h084, 32'h0, 32'h1},                // R7
        {1'b1, 9'h081, 32'h0, 32'hA},                // R10
        {1'b1, 9'h082, 32'h0, 32'h0},                // R10
        {1'b0, 9'h085, 32'h7, 32'h0},
        {1'b1, 9'h085, 32'h0, 32'h7},                // R8
        {1'b0, 9'h080, 32'h0, 32'h0},
        {1'b1, 9'h083, 32'h0, 32'h0},                // R6 other lane untouched
        {1'b0, 9'h1FF, 32'h5A, 32'h0},
        {1'b1, 9'h1FF, 32'h0, 32'h0},                // R11
        {1'b0, 9'h080, 32'h9, 32'h0},
        {1'b0, 9'h083, 32'h3F, 32'h0},               // R11 ignored write
        {1'b0, 9'h080, 32'h2, 32'h0},
        {1'b1, 9'h083, 32'h0, 32'h2B}                // R11 lane 2 kept
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        #1 if (wait_req) hs_ok = 1'b0;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_read(input logic [8:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 if (!wait_req) hs_ok = 1'b0;
        @(negedge clk);
        if (wait_req) hs_ok = 1'b0;
        v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic chk_reset_state(input string req);
        chk(cal_pd == 0 && serial_lpbk == 0 && cdr_ltd_req == 0 && cdr_ltr_req == 0,
            req, 32'(cal_pd | serial_lpbk | cdr_ltd_req | cdr_ltr_req), 32'h0);
        chk(tx_slip_sel == 0 && tx_inv == 0 && rx_inv == 0 && rx_slip_pulse == 0 &&
            byte_rev == 0 && bit_rev == 0 && pat_align == 0,
            req, 32'(tx_slip_sel), 32'h0);
        chk(!manual_mode && !wait_req && rdata == 0, req, rdata, 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset_state("R1");

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][73]) begin
                do_read(VEC[i][72:64], v);
                chk(v === VEC[i][31:0], $sformatf("R3-R11 vec %0d", i), v, VEC[i][31:0]);
            end else begin
                do_write(VEC[i][72:64], VEC[i][63:32]);
            end
        end

        // Output pins after the table (R3, R5, R7, R8)
        chk(cal_pd == 4'hF && serial_lpbk == 4'h5 && cdr_ltr_req == 4'h3, "R3 pins",
            32'({cal_pd, serial_lpbk, cdr_ltr_req}), 32'hF53);
        chk(manual_mode == 1'b1, "R5 ltr set", 32'(manual_mode), 32'h1);
        chk(tx_slip_sel[14:10] == 5'h15 && tx_inv == 4'b0100 && rx_inv == 4'b0100, "R7 pins",
            32'({tx_slip_sel, tx_inv, rx_inv}), 32'({5'h15, 10'h0, 4'b0100, 4'b0100}));
        chk(byte_rev == 4'b0100 && bit_rev == 4'b0100 && pat_align == 4'b0100, "R8 pins",
            32'({byte_rev, bit_rev, pat_align}), 32'h444);

        // R5: clear lock masks, then set lock-to-data
        do_write(9'h065, 32'h0);
        chk(manual_mode == 1'b0, "R5 cleared", 32'(manual_mode), 32'h0);
        do_write(9'h064, 32'h8);
        chk(manual_mode == 1'b1 && cdr_ltd_req == 4'h8, "R5 ltd set",
            32'({manual_mode, cdr_ltd_req}), 32'h18);
        do_write(9'h064, 32'h0);
        chk(manual_mode == 1'b0, "R5 ltd cleared", 32'(manual_mode), 32'h0);

        // R9: bit-slip pulse on lane 1
        do_write(9'h080, 32'h1);
        do_write(9'h085, 32'h8);
        chk(rx_slip_pulse == 4'b0010, "R9 pulse", 32'(rx_slip_pulse), 32'h2);
        @(negedge clk);
        chk(rx_slip_pulse == 4'b0000, "R9 one cycle", 32'(rx_slip_pulse), 32'h0);
        do_write(9'h085, 32'h8);
        chk(rx_slip_pulse == 4'b0000, "R9 held no pulse", 32'(rx_slip_pulse), 32'h0);
        do_write(9'h085, 32'h0);
        do_write(9'h085, 32'h8);
        chk(rx_slip_pulse == 4'b0010, "R9 re-arm", 32'(rx_slip_pulse), 32'h2);
        do_read(9'h085, v);
        chk(v == 32'h8, "R8 slip bit readback", v, 32'h8);

        // R2: every transfer followed the handshake
        chk(hs_ok, "R2 handshake", 32'(hs_ok), 32'h1);

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_reset_state("R1 rerun");
        do_read(9'h080, v);
        chk(v == 32'h0, "R1 lane sel", v, 32'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end
endmodule